// File: doc/BRIEF.md
# ADC Channel Scan Trigger Controller

This block sits between a processor bus and a multichannel analog-to-digital converter. Software programs a scan window as two packed channel numbers in one register: the first channel in the low nibble and the last channel in the high nibble. It also picks one of four trigger sources. The controller drives the analog multiplexer select and issues one-cycle convert-start pulses. It steps the multiplexer by one channel each time the converter reports completion, and it returns to the first channel after the last one.

Conversions can be started in three ways. The first is a direct software write. The second is a periodic tick from an external pacer counter. The third is a rising edge on an asynchronous pacer pin, which is synchronised inside the block. In both paced modes, a write to the data address only arms the pacer, and a rising edge on the asynchronous trigger pin can arm it as well. Each completed result is held left-justified for the bus to read. Every write to the range register pulses a reset to the downstream sample FIFO.

Top module: `adc_scan_ctrl`

## Requirements
- R1: A write to address 1 loads bits [3:0] as the low channel and bits [7:4] as the high channel, and sets the current channel to the low channel. `fifo_rst` is high for exactly the one cycle after that write and is low at all other times.
- R2: A read of address 1 returns the high channel in bits [7:4] and the current channel (the one the next trigger will convert) in bits [3:0], with bits [15:8] zero.
- R3: Address 2 is the control register, with bits [1:0] as the trigger mode: 00 software, 01 internal pacer, 10 external pacer, 11 idle. A write to it clears the pacer enable and the overrun flag. A read returns the mode in [1:0], the pacer enable in bit 2 and the overrun flag in bit 3.
- R4: In mode 00, a write to address 0 raises `conv_start` for exactly one cycle, in the cycle after the write, while `mux_sel` holds the current channel.
- R5: Each `conv_done` that ends a conversion advances the current channel by one, and the channel returns to the low channel after the high channel. Range 0x20 gives 0,1,2,0; range 0x65 gives 5,6,5; range 0x11 gives 1,1.
- R6: When the low channel is greater than the high channel, every conversion uses the low channel.
- R7: In modes 01 and 10, a write to address 0 sets the pacer enable and starts no conversion by itself.
- R8: In mode 01 with the pacer enabled, each cycle with `pacer_tick` high starts one conversion. Ticks are ignored while the pacer is disabled and in every other mode.
- R9: In mode 10 with the pacer enabled, each rising edge of `ext_pacer`, taken through a two-flop synchroniser, starts one conversion. Edges are ignored while the pacer is disabled.
- R10: A synchronised rising edge of `ext_trig` in mode 01 or mode 10 sets the pacer enable.
- R11: In mode 11, no source starts a conversion.
- R12: A convert request that arrives after `conv_start` and before the matching `conv_done` is ignored. It sets `overrun`, which stays high until the next control write.
- R13: `conv_data` is captured on `conv_done`, and a read of address 0 returns it left-justified, with the converter MSB in bit 15 and its LSB in bit 0.
- R14: After reset, the scan range is 0x00, the mode is 00, the pacer is disabled, `mux_sel` is 0, and `conv_start`, `fifo_rst` and `overrun` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 2 | Register address |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_rd | input | 1 | Read strobe; read data is valid in the same cycle |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Read data, zero when no read is active |
| pacer_tick | input | 1 | Synchronous tick from the pacer counter |
| ext_pacer | input | 1 | Asynchronous external pacer pin |
| ext_trig | input | 1 | Asynchronous external trigger/gate pin |
| mux_sel | output | 4 | Analog multiplexer channel select |
| conv_start | output | 1 | One-cycle convert-start pulse |
| conv_done | input | 1 | Converter completion strobe |
| conv_data | input | 16 | Converter result, valid with conv_done |
| fifo_rst | output | 1 | One-cycle sample FIFO reset |
| overrun | output | 1 | Sticky flag for a request that was dropped |

## Verification
The hardest state to reach is a dropped request during a conversion that is still in progress. The bench reaches it with a slow converter model that waits 30 cycles before it answers. During that wait it issues a second software write, and it then checks that no extra start appears and that the flag stays set until a control write clears it. The paced modes are also hard to reach, because a correct design must stay silent there until it is armed. The stimulus therefore sends ticks and pin edges both before and after arming, and any start that the scoreboard did not queue counts as a mismatch.

// File: rtl/adc_scan_pkg.sv
package adc_scan_pkg;

   typedef enum logic [1:0] {
      TRIG_SOFT = 2'b00,
      TRIG_INT  = 2'b01,
      TRIG_EXT  = 2'b10,
      TRIG_IDLE = 2'b11
   } trig_mode_e;

   localparam int REG_DATA  = 0;
   localparam int REG_RANGE = 1;
   localparam int REG_CTRL  = 2;

   localparam int CTRL_PACER_BIT = 2;
   localparam int CTRL_OVR_BIT   = 3;

endpackage

// File: rtl/adc_edge_sync.sv
module adc_edge_sync #(
   parameter int N      = 2,
   parameter int STAGES = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] din,
   output logic [N-1:0] rise
);

   if (STAGES < 2) begin : g_bad_stages
      $error("adc_edge_sync: STAGES must be at least 2");
   end
   if (N < 1) begin : g_bad_n
      $error("adc_edge_sync: N must be at least 1");
   end

   for (genvar i = 0; i < N; i++) begin : g_bit
      logic [STAGES:0] chain;
      always_ff @(posedge clk) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[STAGES-1:0], din[i]};
      end
      assign rise[i] = chain[STAGES-1] & ~chain[STAGES];
   end

endmodule

// File: rtl/adc_scan_seq.sv
module adc_scan_seq #(
   parameter int CH_W = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic [2*CH_W-1:0] load_val,
   input  logic              advance,
   output logic [CH_W-1:0]   cur,
   output logic [CH_W-1:0]   lo,
   output logic [CH_W-1:0]   hi
);

   logic [CH_W-1:0] next_ch;
   logic            wrap;

   assign wrap    = (lo > hi) || (cur >= hi);
   assign next_ch = wrap ? lo : cur + 1'b1;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         lo  <= '0;
         hi  <= '0;
         cur <= '0;
      end else if (load) begin
         lo  <= load_val[CH_W-1:0];
         hi  <= load_val[2*CH_W-1:CH_W];
         cur <= load_val[CH_W-1:0];
      end else if (advance) begin
         cur <= next_ch;
      end
   end

endmodule

// File: rtl/adc_trig_ctrl.sv
module adc_trig_ctrl
   import adc_scan_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ctrl_we,
   input  logic [1:0] ctrl_mode,
   input  logic       data_we,
   input  logic       tick,
   input  logic       pacer_rise,
   input  logic       trig_rise,
   input  logic       done,
   output logic [1:0] mode,
   output logic       pacer_en,
   output logic       busy,
   output logic       overrun,
   output logic       start,
   output logic       accept_done
);

   trig_mode_e mode_q;
   logic       paced;
   logic       req;
   logic       launch;

   assign paced  = (mode_q == TRIG_INT) || (mode_q == TRIG_EXT);

   always_comb begin
      unique case (mode_q)
         TRIG_SOFT: req = data_we;
         TRIG_INT:  req = pacer_en & tick;
         TRIG_EXT:  req = pacer_en & pacer_rise;
         default:   req = 1'b0;
      endcase
   end

   assign launch      = req & ~busy;
   assign accept_done = done & busy;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q   <= TRIG_SOFT;
         pacer_en <= 1'b0;
         busy     <= 1'b0;
         overrun  <= 1'b0;
         start    <= 1'b0;
      end else begin
         start <= launch;
         if (launch)           busy <= 1'b1;
         else if (accept_done) busy <= 1'b0;
         if (ctrl_we) begin
            mode_q   <= trig_mode_e'(ctrl_mode);
            pacer_en <= 1'b0;
            overrun  <= 1'b0;
         end else begin
            if (paced && (data_we || trig_rise)) pacer_en <= 1'b1;
            if (req && busy)                     overrun  <= 1'b1;
         end
      end
   end

   assign mode = mode_q;

endmodule

// File: rtl/adc_result_reg.sv
module adc_result_reg #(
   parameter int ADC_W  = 16,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              capture,
   input  logic [ADC_W-1:0]  sample,
   output logic [DATA_W-1:0] word
);

   logic [DATA_W-1:0] justified;

   if (ADC_W > DATA_W) begin : g_bad_width
      $error("adc_result_reg: ADC_W must not exceed DATA_W");
   end else if (ADC_W == DATA_W) begin : g_full
      assign justified = sample;
   end else begin : g_pad
      assign justified = {sample, {(DATA_W-ADC_W){1'b0}}};
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       word <= '0;
      else if (capture) word <= justified;
   end

endmodule

// File: rtl/adc_scan_ctrl.sv
module adc_scan_ctrl
   import adc_scan_pkg::*;
#(
   parameter int DATA_W      = 16,
   parameter int ADDR_W      = 2,
   parameter int CH_W        = 4,
   parameter int ADC_W       = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              pacer_tick,
   input  logic              ext_pacer,
   input  logic              ext_trig,
   output logic [CH_W-1:0]   mux_sel,
   output logic              conv_start,
   input  logic              conv_done,
   input  logic [ADC_W-1:0]  conv_data,
   output logic              fifo_rst,
   output logic              overrun
);

   localparam int RANGE_W = 2 * CH_W;

   if (RANGE_W > DATA_W) begin : g_bad_range
      $error("adc_scan_ctrl: two channel nibbles must fit in the bus word");
   end
   if (DATA_W < 4) begin : g_bad_bus
      $error("adc_scan_ctrl: bus too narrow for the control register");
   end
   if (ADDR_W < 2) begin : g_bad_addr
      $error("adc_scan_ctrl: ADDR_W must be at least 2");
   end

   logic            data_we, range_we, ctrl_we;
   logic [1:0]      mode;
   logic            pacer_en, busy, accept_done;
   logic [1:0]      edge_in, edge_rise;
   logic [CH_W-1:0] scan_lo, scan_hi, scan_cur;
   logic [DATA_W-1:0] result_word;
   logic [DATA_W-1:0] rd_mux;
   logic              wdata_unused;

   assign data_we  = bus_wr && (bus_addr == ADDR_W'(REG_DATA));
   assign range_we = bus_wr && (bus_addr == ADDR_W'(REG_RANGE));
   assign ctrl_we  = bus_wr && (bus_addr == ADDR_W'(REG_CTRL));

   if (DATA_W > RANGE_W) begin : g_wd_spare
      assign wdata_unused = ^bus_wdata[DATA_W-1:RANGE_W];
   end else begin : g_wd_full
      assign wdata_unused = 1'b0;
   end

   assign edge_in = {ext_trig, ext_pacer};

   adc_edge_sync #(
      .N      (2),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (edge_in),
      .rise  (edge_rise)
   );

   adc_trig_ctrl u_trig (
      .clk         (clk),
      .rst_n       (rst_n),
      .ctrl_we     (ctrl_we),
      .ctrl_mode   (bus_wdata[1:0]),
      .data_we     (data_we),
      .tick        (pacer_tick),
      .pacer_rise  (edge_rise[0]),
      .trig_rise   (edge_rise[1]),
      .done        (conv_done),
      .mode        (mode),
      .pacer_en    (pacer_en),
      .busy        (busy),
      .overrun     (overrun),
      .start       (conv_start),
      .accept_done (accept_done)
   );

   adc_scan_seq #(
      .CH_W (CH_W)
   ) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (range_we),
      .load_val (bus_wdata[RANGE_W-1:0]),
      .advance  (accept_done),
      .cur      (scan_cur),
      .lo       (scan_lo),
      .hi       (scan_hi)
   );

   adc_result_reg #(
      .ADC_W  (ADC_W),
      .DATA_W (DATA_W)
   ) u_result (
      .clk     (clk),
      .rst_n   (rst_n),
      .capture (accept_done),
      .sample  (conv_data),
      .word    (result_word)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) fifo_rst <= 1'b0;
      else        fifo_rst <= range_we;
   end

   always_comb begin
      rd_mux = '0;
      if (bus_addr == ADDR_W'(REG_DATA)) begin
         rd_mux = result_word;
      end else if (bus_addr == ADDR_W'(REG_RANGE)) begin
         rd_mux[RANGE_W-1:0] = {scan_hi, scan_cur};
      end else if (bus_addr == ADDR_W'(REG_CTRL)) begin
         rd_mux[1:0]            = mode;
         rd_mux[CTRL_PACER_BIT] = pacer_en;
         rd_mux[CTRL_OVR_BIT]   = overrun;
      end
   end

   assign bus_rdata = bus_rd ? rd_mux : '0;
   assign mux_sel   = scan_cur;

endmodule

// File: rtl/adc_scan_chk.sv
module adc_scan_chk #(
   parameter int CH_W = 4
) (
   input logic            clk,
   input logic            rst_n,
   input logic            range_we,
   input logic            ctrl_we,
   input logic            fifo_rst,
   input logic            conv_start,
   input logic            busy,
   input logic            overrun,
   input logic [1:0]      mode,
   input logic [CH_W-1:0] mux_sel,
   input logic [CH_W-1:0] lo,
   input logic [CH_W-1:0] hi
);

   AST_FIFO_RST_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      range_we |=> fifo_rst);                                   // R1
   AST_FIFO_RST_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
      !range_we |=> !fifo_rst);                                 // R1
   AST_CTRL_CLEARS_OVR: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_we |=> !overrun);                                    // R3
   AST_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      conv_start |=> !conv_start);                              // R4
   AST_MUX_IN_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
      (lo <= hi) |-> (mux_sel >= lo && mux_sel <= hi));         // R5
   AST_MUX_FIXED_LOW: assert property (@(posedge clk) disable iff (!rst_n)
      (lo > hi) |-> (mux_sel == lo));                           // R6
   AST_IDLE_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
      (mode == 2'b11 && !ctrl_we) |=> !conv_start);             // R11
   AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !conv_start);                                    // R12
   AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      (overrun && !ctrl_we) |=> overrun);                       // R12

endmodule

bind adc_scan_ctrl adc_scan_chk #(.CH_W(CH_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .range_we   (range_we),
   .ctrl_we    (ctrl_we),
   .fifo_rst   (fifo_rst),
   .conv_start (conv_start),
   .busy       (busy),
   .overrun    (overrun),
   .mode       (mode),
   .mux_sel    (mux_sel),
   .lo         (scan_lo),
   .hi         (scan_hi)
);

// File: tb/tb_adc_scan_ctrl.sv
module tb_adc_scan_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  bus_addr = '0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [15:0] bus_wdata = '0;
   logic [15:0] bus_rdata;
   logic        pacer_tick = 1'b0;
   logic        ext_pacer = 1'b0;
   logic        ext_trig = 1'b0;
   logic [3:0]  mux_sel;
   logic        conv_start;
   logic        conv_done = 1'b0;
   logic [15:0] conv_data = '0;
   logic        fifo_rst;
   logic        overrun;

   int n_cmp = 0;
   int n_bad = 0;
   int resp_lat = 4;
   int conv_count = 0;
   bit live = 0;
   logic [15:0] last_data = '0;
   int exp_q[$];
   int m_lo = 0, m_hi = 0, m_cur = 0;

   always #2 clk = ~clk;

   adc_scan_ctrl dut (
      .clk        (clk),
      .rst_n      (rst_n),
      .bus_addr   (bus_addr),
      .bus_wr     (bus_wr),
      .bus_rd     (bus_rd),
      .bus_wdata  (bus_wdata),
      .bus_rdata  (bus_rdata),
      .pacer_tick (pacer_tick),
      .ext_pacer  (ext_pacer),
      .ext_trig   (ext_trig),
      .mux_sel    (mux_sel),
      .conv_start (conv_start),
      .conv_done  (conv_done),
      .conv_data  (conv_data),
      .fifo_rst   (fifo_rst),
      .overrun    (overrun)
   );

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   endtask

   // scoreboard monitor: every start pops one expected channel
   initial begin
      forever begin
         @(negedge clk);
         if (live && conv_start) begin
            if (exp_q.size() == 0) begin
               chk(1'b0, "R4/R7/R8/R9/R11/R12 unexpected conv_start, mux", int'(mux_sel), -1);
            end else begin
               int e;
               e = exp_q.pop_front();
               chk(int'(mux_sel) == e, "R4/R5/R6 channel at conv_start", int'(mux_sel), e);
            end
         end
      end
   end

   // converter model
   initial begin
      forever begin
         @(negedge clk);
         if (conv_start) begin
            logic [3:0] ch;
            ch = mux_sel;
            repeat (resp_lat - 1) @(negedge clk);
            conv_count++;
            conv_data = 16'h8001 | (16'(ch) << 8) | (16'(conv_count & 7) << 4);
            last_data = conv_data;
            conv_done = 1'b1;
            @(negedge clk);
            conv_done = 1'b0;
         end
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog expired actual=%0d expected=0", 1);
      finish_run();
   end

   task automatic wr(input logic [1:0] a, input logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [15:0] d);
      @(negedge clk);
      bus_addr = a; bus_rd = 1'b1;
      #1 d = bus_rdata;
      bus_rd = 1'b0;
   endtask

   task automatic settle();
      repeat (resp_lat + 12) @(negedge clk);
   endtask

   task automatic set_range(input logic [7:0] v);
      @(negedge clk);
      bus_addr = 2'd1; bus_wdata = {8'h00, v}; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
      chk(fifo_rst == 1'b1, "R1 fifo_rst after range write", int'(fifo_rst), 1);
      @(negedge clk);
      chk(fifo_rst == 1'b0, "R1 fifo_rst one cycle only", int'(fifo_rst), 0);
      m_lo = int'(v[3:0]); m_hi = int'(v[7:4]); m_cur = m_lo;
   endtask

   task automatic expect_conv();
      exp_q.push_back(m_cur);
      if (m_lo > m_hi || m_cur >= m_hi) m_cur = m_lo;
      else                              m_cur = m_cur + 1;
   endtask

   task automatic soft_convs(input int n);
      for (int i = 0; i < n; i++) begin
         expect_conv();
         wr(2'd0, 16'h0);
         settle();
      end
      chk(exp_q.size() == 0, "R4 all expected conversions seen", exp_q.size(), 0);
   endtask

   task automatic pulse_tick();
      @(negedge clk); pacer_tick = 1'b1;
      @(negedge clk); pacer_tick = 1'b0;
      settle();
   endtask

   task automatic pulse_pin(input bit which_trig);
      @(negedge clk);
      if (which_trig) ext_trig = 1'b1; else ext_pacer = 1'b1;
      repeat (4) @(negedge clk);
      if (which_trig) ext_trig = 1'b0; else ext_pacer = 1'b0;
      settle();
   endtask

   initial begin
      logic [15:0] r;
      repeat (5) @(negedge clk);
      rst_n = 1'b1;
      live = 1;
      @(negedge clk);

      // R14 reset state
      chk(mux_sel == 4'd0, "R14 mux_sel after reset", int'(mux_sel), 0);
      chk(conv_start == 1'b0, "R14 conv_start after reset", int'(conv_start), 0);
      chk(fifo_rst == 1'b0, "R14 fifo_rst after reset", int'(fifo_rst), 0);
      chk(overrun == 1'b0, "R14 overrun after reset", int'(overrun), 0);
      rd(2'd1, r); chk(r == 16'h0000, "R14 range after reset", int'(r), 0);
      rd(2'd2, r); chk(r == 16'h0000, "R14 control after reset", int'(r), 0);

      // R1 R2 R4 R5: window 0..2
      set_range(8'h20);
      rd(2'd1, r); chk(r == 16'h0020, "R2 range readback", int'(r), 'h20);
      soft_convs(4);
      rd(2'd1, r); chk(r == 16'(m_hi * 16 + m_cur), "R2 next channel readback", int'(r), m_hi * 16 + m_cur);
      rd(2'd0, r); chk(r == last_data, "R13 left-justified result", int'(r), int'(last_data));

      set_range(8'h65); soft_convs(3);
      rd(2'd0, r); chk(r == last_data, "R13 result after 0x65 scan", int'(r), int'(last_data));
      set_range(8'h11); soft_convs(2);

      // R6 low above high
      set_range(8'h35); soft_convs(3);
      rd(2'd1, r); chk(r == 16'h0035, "R6 channel held at low", int'(r), 'h35);

      // R7 R8 internal pacer
      wr(2'd2, 16'h0001);
      set_range(8'h30);
      pulse_tick(); pulse_tick();
      rd(2'd2, r); chk(r == 16'h0001, "R8 mode 01 pacer still disabled", int'(r), 1);
      wr(2'd0, 16'h0); settle();
      rd(2'd2, r); chk(r == 16'h0005, "R7 data write arms pacer", int'(r), 5);
      for (int i = 0; i < 3; i++) begin
         expect_conv();
         pulse_tick();
      end
      chk(exp_q.size() == 0, "R8 tick conversions seen", exp_q.size(), 0);

      // R10 trigger pin arms internal pacer
      wr(2'd2, 16'h0001);
      pulse_tick();
      pulse_pin(1'b1);
      rd(2'd2, r); chk(r == 16'h0005, "R10 ext_trig arms in mode 01", int'(r), 5);
      expect_conv(); pulse_tick();
      chk(exp_q.size() == 0, "R10 conversion after trig arm", exp_q.size(), 0);

      // R9 R10 external pacer
      wr(2'd2, 16'h0002);
      pulse_pin(1'b0);
      pulse_tick();
      pulse_pin(1'b1);
      rd(2'd2, r); chk(r == 16'h0006, "R10 ext_trig arms in mode 10", int'(r), 6);
      for (int i = 0; i < 3; i++) begin
         expect_conv();
         pulse_pin(1'b0);
      end
      pulse_tick();
      chk(exp_q.size() == 0, "R9 pacer edge conversions seen", exp_q.size(), 0);

      // R11 idle mode
      wr(2'd2, 16'h0003);
      wr(2'd0, 16'h0); settle();
      pulse_tick(); pulse_pin(1'b1); pulse_pin(1'b0);
      rd(2'd2, r); chk(r == 16'h0003, "R11 idle mode control readback", int'(r), 3);

      // R12 overrun while busy, R3 clear
      wr(2'd2, 16'h0000);
      resp_lat = 30;
      expect_conv();
      wr(2'd0, 16'h0);
      repeat (3) @(negedge clk);
      wr(2'd0, 16'h0);
      settle();
      chk(overrun == 1'b1, "R12 overrun set by dropped request", int'(overrun), 1);
      chk(exp_q.size() == 0, "R12 single conversion only", exp_q.size(), 0);
      rd(2'd2, r); chk(r == 16'h0008, "R3 overrun bit in control", int'(r), 8);
      wr(2'd2, 16'h0000);
      @(negedge clk);
      chk(overrun == 1'b0, "R3 control write clears overrun", int'(overrun), 0);
      resp_lat = 4;
      soft_convs(1);

      finish_run();
   end

endmodule